// File: doc/BRIEF.md
# Two-Phase Synchronous Buck Gate Sequencer

This block drives the high-side and low-side switch enables of a set of synchronous buck power stages that share one timing source. A fast system clock is divided by a counter into a switching period. Each converter takes its own cycle-start strobe from that counter, at evenly spaced offsets. With the default of two converters, converter 1 starts at count zero and converter 2 starts half a period later, so the two stages run 180 degrees apart.

Each converter has a small state machine. It waits for its cycle start, inserts a programmable gap during which both switches are off, and then turns the high side on. A comparator trip or a high-side over-current flag ends the high-side pulse. After another gap the low side turns on and stays on until the next cycle start. If the low-side over-current flag is still set at a cycle start, the low side is held on and the high-side pulse for that cycle is skipped. A full-duty request keeps the high side on across cycle starts. Dropping either the enable or the burst enable turns both switches off at once.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every `p_gate` and `n_gate` bit is 0.
- R2: The switching period is `PERIOD` system clocks. Converter k starts its cycle when the divider count equals k*PERIOD/N_CONV, and the count is 0 in the first cycle after reset. With two converters, the high-side turn-on of converter 2 lags converter 1 by PERIOD/2 clocks.
- R3: At a cycle start, an active converter that has its low side on (or both switches off) turns both switches off for `dead_ticks` clocks and then turns its high side on.
- R4: While the high side is on and `full_duty` is low, a high `pwm_trip` turns the high side off at the next edge. The low side then turns on after `dead_ticks` clocks with both switches off, and it stays on until the next cycle start.
- R5: A high `p_oc` turns the high side off at the next edge and starts the low-side sequence of R4. This holds even when `full_duty` is high.
- R6: If `n_oc` is high at a cycle start while the low side is on, the low side stays on and the high side is not turned on in that cycle.
- R7: While `full_duty` is high and `p_oc` is low, the high side stays on through cycle starts, and `pwm_trip` has no effect on it.
- R8: When `en` or `burst_en` of a converter is low at an edge, both of its switches are off after that edge, and its gap timer is cleared.
- R9: The high side and low side of one converter are never on in the same cycle.
- R10: With `dead_ticks` equal to 0, the sequencer switches from one side to the other at a single edge, with no cycle in which both switches are off.
- R11: The converters run independently. Inputs of one converter never change the gates of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| dead_ticks | input | DT_W | Gap length in system clocks, shared by all converters |
| en | input | N_CONV | Per-converter enable |
| burst_en | input | N_CONV | Per-converter burst/run permission from the mode controller |
| pwm_trip | input | N_CONV | PWM comparator trip, ends the high-side pulse |
| p_oc | input | N_CONV | High-side over-current flag |
| n_oc | input | N_CONV | Low-side over-current flag |
| full_duty | input | N_CONV | Request to keep the high side on continuously |
| p_gate | output | N_CONV | Registered high-side switch enable |
| n_gate | output | N_CONV | Registered low-side switch enable |

## Verification
If a converter's sequencing state is corrupted, it shows at the gate outputs by the next edge. The result can be both switches on together, a missing gap, or a high-side pulse that starts although the low-side current is still over its limit. If the phase divider is wrong, the high-side rising edges move. They then no longer repeat every PERIOD clocks, or the two converters lose their half-period offset. This is visible within one period. A scoreboard model runs cycle by cycle next to directed scenarios and a seeded random run. It catches wrong timing in the gap counter on the first pulse after a gap-length change.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    LEG_IDLE   = 3'd0,
    LEG_GAP_HI = 3'd1,
    LEG_HI     = 3'd2,
    LEG_GAP_LO = 3'd3,
    LEG_LO     = 3'd4
  } leg_state_t;

endpackage

// File: rtl/buck_phase_div.sv
module buck_phase_div #(
  parameter int PERIOD = 16,
  parameter int N_CONV = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [N_CONV-1:0] cyc_start
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // evenly spaced start offsets, one per converter
  for (genvar k = 0; k < N_CONV; k++) begin : g_ph
    localparam logic [CNT_W-1:0] OFS = CNT_W'((k * PERIOD) / N_CONV);
    assign cyc_start[k] = (cnt == OFS);
  end
endmodule

// File: rtl/buck_leg_fsm.sv
module buck_leg_fsm
  import buck_seq_pkg::*;
#(
  parameter int DT_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_start,
  input  logic            active,
  input  logic            trip,
  input  logic            hs_oc,
  input  logic            ls_oc,
  input  logic            full,
  input  logic [DT_W-1:0] dead,
  output logic            hs_on,
  output logic            ls_on
);
  leg_state_t      st, st_nxt;
  logic [DT_W-1:0] gap, gap_nxt;
  logic            dead_zero;

  assign dead_zero = (dead == '0);

  always_comb begin
    st_nxt  = st;
    gap_nxt = gap;
    if (!active) begin
      st_nxt  = LEG_IDLE;
      gap_nxt = '0;
    end else begin
      case (st)
        LEG_IDLE, LEG_LO: begin
          if (cyc_start) begin
            if (st == LEG_LO && ls_oc) begin
              st_nxt = LEG_LO;
            end else if (dead_zero) begin
              st_nxt = LEG_HI;
            end else begin
              st_nxt  = LEG_GAP_HI;
              gap_nxt = dead - 1'b1;
            end
          end
        end
        LEG_GAP_HI: begin
          if (gap == '0) st_nxt = LEG_HI;
          else           gap_nxt = gap - 1'b1;
        end
        LEG_HI: begin
          if (hs_oc || (trip && !full)) begin
            if (dead_zero) begin
              st_nxt = LEG_LO;
            end else begin
              st_nxt  = LEG_GAP_LO;
              gap_nxt = dead - 1'b1;
            end
          end
        end
        LEG_GAP_LO: begin
          if (gap == '0) st_nxt = LEG_LO;
          else           gap_nxt = gap - 1'b1;
        end
        default: begin
          st_nxt  = LEG_IDLE;
          gap_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LEG_IDLE;
      gap   <= '0;
      hs_on <= 1'b0;
      ls_on <= 1'b0;
    end else begin
      st    <= st_nxt;
      gap   <= gap_nxt;
      hs_on <= (st_nxt == LEG_HI);
      ls_on <= (st_nxt == LEG_LO);
    end
  end
endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer #(
  parameter int PERIOD = 16,
  parameter int N_CONV = 2,
  parameter int DT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DT_W-1:0]   dead_ticks,
  input  logic [N_CONV-1:0] en,
  input  logic [N_CONV-1:0] burst_en,
  input  logic [N_CONV-1:0] pwm_trip,
  input  logic [N_CONV-1:0] p_oc,
  input  logic [N_CONV-1:0] n_oc,
  input  logic [N_CONV-1:0] full_duty,
  output logic [N_CONV-1:0] p_gate,
  output logic [N_CONV-1:0] n_gate
);
  logic [N_CONV-1:0] cyc_start;

  buck_phase_div #(.PERIOD(PERIOD), .N_CONV(N_CONV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start)
  );

  for (genvar i = 0; i < N_CONV; i++) begin : g_leg
    buck_leg_fsm #(.DT_W(DT_W)) u_leg (
      .clk       (clk),
      .rst       (rst),
      .cyc_start (cyc_start[i]),
      .active    (en[i] & burst_en[i]),
      .trip      (pwm_trip[i]),
      .hs_oc     (p_oc[i]),
      .ls_oc     (n_oc[i]),
      .full      (full_duty[i]),
      .dead      (dead_ticks),
      .hs_on     (p_gate[i]),
      .ls_on     (n_gate[i])
    );
  end
endmodule

// File: rtl/buck_gate_sequencer_chk.sv
module buck_gate_sequencer_chk #(
  parameter int N_CONV = 2,
  parameter int DT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DT_W-1:0]   dead_ticks,
  input logic [N_CONV-1:0] en,
  input logic [N_CONV-1:0] burst_en,
  input logic [N_CONV-1:0] p_oc,
  input logic [N_CONV-1:0] n_oc,
  input logic [N_CONV-1:0] full_duty,
  input logic [N_CONV-1:0] p_gate,
  input logic [N_CONV-1:0] n_gate
);
  for (genvar i = 0; i < N_CONV; i++) begin : g_c
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
      !(p_gate[i] && n_gate[i]));

    assert_off_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !(en[i] && burst_en[i]) |=> (!p_gate[i] && !n_gate[i]));

    assert_gap_before_hs_R3: assert property (@(posedge clk) disable iff (rst)
      ($rose(p_gate[i]) && ($past(dead_ticks) != '0)) |-> !$past(n_gate[i]));

    assert_gap_before_ls_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(n_gate[i]) && ($past(dead_ticks) != '0)) |-> !$past(p_gate[i]));

    assert_hs_limit_R5: assert property (@(posedge clk) disable iff (rst)
      (p_gate[i] && p_oc[i]) |=> !p_gate[i]);

    assert_ls_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (n_gate[i] && n_oc[i]) |=> !p_gate[i]);

    assert_full_duty_R7: assert property (@(posedge clk) disable iff (rst)
      (p_gate[i] && full_duty[i] && !p_oc[i] && en[i] && burst_en[i]) |=> p_gate[i]);
  end
endmodule

bind buck_gate_sequencer buck_gate_sequencer_chk #(.N_CONV(N_CONV), .DT_W(DT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dead_ticks (dead_ticks),
  .en         (en),
  .burst_en   (burst_en),
  .p_oc       (p_oc),
  .n_oc       (n_oc),
  .full_duty  (full_duty),
  .p_gate     (p_gate),
  .n_gate     (n_gate)
);

// File: tb/sim_buck_gate_sequencer.sv
module sim_buck_gate_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 16;
  localparam int NC         = 2;
  localparam int DT_W       = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [DT_W-1:0] dead_ticks = 3'd2;
  logic [NC-1:0]   en = '0, burst_en = '0, pwm_trip = '0, p_oc = '0, n_oc = '0, full_duty = '0;
  logic [NC-1:0]   p_gate, n_gate;

  int n_chk = 0, n_fail = 0, ncyc = 0;
  string req = "R1";
  int    m_st[NC];
  int    m_gap[NC];
  int    m_cnt;
  int    rise_last[NC], rise_prev[NC];
  logic [NC-1:0] p_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_gate_sequencer #(.PERIOD(PERIOD), .N_CONV(NC), .DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .dead_ticks(dead_ticks), .en(en), .burst_en(burst_en),
    .pwm_trip(pwm_trip), .p_oc(p_oc), .n_oc(n_oc), .full_duty(full_duty),
    .p_gate(p_gate), .n_gate(n_gate));

  // states: 0 idle, 1 gap before high, 2 high, 3 gap before low, 4 low
  function automatic int start_ofs(int k);
    return (k * PERIOD) / NC;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0;
      for (int k = 0; k < NC; k++) begin m_st[k] <= 0; m_gap[k] <= 0; end
    end else begin
      m_cnt <= (m_cnt == PERIOD - 1) ? 0 : m_cnt + 1;
      for (int k = 0; k < NC; k++) begin
        int s, g, d;
        bit go;
        s = m_st[k]; g = m_gap[k]; d = int'(dead_ticks);
        go = (m_cnt == start_ofs(k));
        if (!(en[k] && burst_en[k])) begin s = 0; g = 0; end
        else if (s == 0 || s == 4) begin
          if (go && !(s == 4 && n_oc[k])) begin
            if (d == 0) s = 2; else begin s = 1; g = d - 1; end
          end
        end else if (s == 1 || s == 3) begin
          if (g == 0) s = s + 1; else g = g - 1;
        end else if (s == 2) begin
          if (p_oc[k] || (pwm_trip[k] && !full_duty[k])) begin
            if (d == 0) s = 4; else begin s = 3; g = d - 1; end
          end
        end
        m_st[k]  <= s;
        m_gap[k] <= g;
      end
    end
  end

  task automatic check(bit ok, string r, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ncyc++;
      for (int k = 0; k < NC; k++) begin
        logic [1:0] exp_g, act_g;
        exp_g = {m_st[k] == 2, m_st[k] == 4};
        act_g = {p_gate[k], n_gate[k]};
        check(act_g == exp_g, req, $sformatf("conv%0d {p,n}", k), int'(act_g), int'(exp_g));
        check(!(p_gate[k] && n_gate[k]), "R9", $sformatf("conv%0d overlap", k), int'(act_g), 0);
        if (p_gate[k] && !p_prev[k]) begin
          rise_prev[k] = rise_last[k];
          rise_last[k] = ncyc;
        end
      end
      p_prev = p_gate;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(p_gate == '0 && n_gate == '0, "R1", "gates in reset", int'({p_gate, n_gate}), 0);
    en = '1; burst_en = '1;
    rst = 1'b0;
    req = "R1";
    step(1);
    check(p_gate == '0 && n_gate == '0, "R1", "gates after release", int'({p_gate, n_gate}), 0);

    // R3: gap then high side, dead 2: converter 1 high rises 3 edges after release
    req = "R3";
    step(2);
    check(p_gate[0] == 1'b1, "R3", "conv0 high after gap", int'(p_gate[0]), 1);
    step(20);

    // R2: trip held high, periodic pulses, check spacing
    req = "R2"; pwm_trip = '1; dead_ticks = 3'd1;
    step(4 * PERIOD);
    check(rise_last[0] - rise_prev[0] == PERIOD, "R2", "conv0 period",
          rise_last[0] - rise_prev[0], PERIOD);
    check((((rise_last[1] - rise_last[0]) % PERIOD) + PERIOD) % PERIOD == PERIOD / 2, "R2",
          "conv1 lag", (((rise_last[1] - rise_last[0]) % PERIOD) + PERIOD) % PERIOD, PERIOD / 2);

    // R4: trip pulse mid cycle
    req = "R4"; pwm_trip = '0; dead_ticks = 3'd2;
    step(2 * PERIOD);
    pwm_trip = 2'b01; step(1); pwm_trip = '0; step(PERIOD);
    pwm_trip = 2'b11; step(3); pwm_trip = '0; step(PERIOD);

    // R7: full duty holds high side despite trips
    req = "R7"; full_duty = '1;
    step(PERIOD);
    pwm_trip = '1; step(2 * PERIOD);
    check(p_gate == '1, "R7", "high side held", int'(p_gate), 3);

    // R5: over-current overrides full duty
    req = "R5"; p_oc = 2'b10; step(1); p_oc = '0;
    step(2);
    check(p_gate[1] == 1'b0, "R5", "conv1 high side cut", int'(p_gate[1]), 0);
    step(PERIOD);
    full_duty = '0;
    p_oc = '1; step(PERIOD); p_oc = '0;

    // R6: low-side over-current blocks next pulse
    req = "R6"; pwm_trip = '1; n_oc = 2'b01;
    step(2 * PERIOD);
    check(p_gate[0] == 1'b0 && n_gate[0] == 1'b1, "R6", "conv0 low held",
          int'({p_gate[0], n_gate[0]}), 1);
    n_oc = '0; step(PERIOD);

    // R10: zero dead time
    req = "R10"; dead_ticks = '0;
    step(3 * PERIOD);

    // R8: drop burst permission
    req = "R8"; pwm_trip = '0; step(PERIOD);
    burst_en = 2'b10; step(1);
    check(p_gate[0] == 1'b0 && n_gate[0] == 1'b0, "R8", "conv0 off", int'({p_gate[0], n_gate[0]}), 0);
    step(PERIOD);
    en = 2'b01; burst_en = '1; step(PERIOD);
    en = '1; step(PERIOD);

    // R11: seeded random independent stimulus
    req = "R11";
    for (int it = 0; it < 4000; it++) begin
      for (int k = 0; k < NC; k++) begin
        en[k]        = ($urandom % 50) != 0;
        burst_en[k]  = ($urandom % 20) != 0;
        pwm_trip[k]  = ($urandom % 5) == 0;
        p_oc[k]      = ($urandom % 25) == 0;
        n_oc[k]      = ($urandom % 3) == 0;
        full_duty[k] = ($urandom % 12) == 0;
      end
      if (it % 64 == 0) dead_ticks = DT_W'($urandom % 4);
      step(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule